// File: doc/BRIEF.md
# Indexed Configuration Register File

This block is a byte-wide bank of 256 configuration registers that a host reaches through two adjacent I/O ports. The lower port holds an index. The upper port reads or writes the register that the index selects. Firmware first writes a register number to the index port, then moves one byte through the data port. A write filter guards the bank. Reserved and fixed registers cannot be written. Two registers take exactly one data value each and discard every other value.

The host opens and closes the window from the host configuration space. A byte written to configuration offset 0x85 sets the window enable from its bit 1. While the window is closed the block claims no I/O cycle and keeps its read data at all ones. The bus interface is single-cycle. A claimed read returns data and an acknowledge in the same cycle as the strobe. A claimed write takes effect at the next clock edge.

Top module: `cfgwin_top`

## Requirements
- R1: After reset the window is closed. A read strobe to 0x3F0 or 0x3F1 gives ioAck = 0 and ioRdata = 0xFF.
- R2: A host configuration write to offset 0x85 sets the window enable to hostCfgData bit 1. Configuration writes to any other offset leave the enable unchanged, and so do the other data bits.
- R3: A claimed write to 0x3F0 stores ioWdata as the current index. A claimed read of 0x3F0 returns the current index. The index resets to 0x00.
- R4: A claimed read of 0x3F1 returns the register at the current index. Reset values are 0xE0 = 0x3C, 0xE2 = 0x03, 0xE3 = 0xFC, 0xE6 = 0xDE, 0xE7 = 0xFE and 0xE8 = 0xBE. Every other register resets to 0x00.
- R5: A claimed write to 0x3F1 stores ioWdata when the index is one of 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 or 0xFC.
- R6: Data-port writes leave the register unchanged when the index is 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF.
- R7: A data-port write to index 0xE7 is kept only if the data is 0xFE. A data-port write to index 0xE8 is kept only if the data is 0xBE.
- R8: While the window is closed, ioAck stays 0 and ioRdata is 0xFF. Writes to either port change neither the index nor any register, which a read after reopening shows.
- R9: Addresses other than 0x3F0 and 0x3F1 are never claimed: ioAck = 0 and ioRdata = 0xFF. Writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostCfgWr | input | 1 | Host configuration byte write strobe |
| hostCfgOffset | input | 8 | Host configuration byte offset |
| hostCfgData | input | 8 | Host configuration write data |
| ioAddr | input | 16 | I/O address |
| ioWr | input | 1 | I/O write strobe |
| ioRd | input | 1 | I/O read strobe |
| ioWdata | input | 8 | I/O write data |
| ioRdata | output | 8 | I/O read data, 0xFF when not claimed |
| ioAck | output | 1 | Cycle claimed by this block |

## Verification
The hardest case to reach is a write that the filter rejects. A rejected write is only visible as a register that keeps its old value, so the bench seeds a writable register with a known value first and reads it back after each attempt. For the value-locked registers, the rejected value is always chosen to differ from the reset value. A closed window has a similar problem. The bench writes a new index and new data while the window is closed, reopens it, and reads back both the index and the register the index pointed to.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  typedef struct packed {
    logic idxWr;
    logic dataWr;
    logic idxRd;
    logic dataRd;
  } cfgStrobes_t;

  // Registers that hold a flop: everything outside the protection map.
  function automatic logic regIsWritable(input int idx);
    logic blocked;
    blocked = (idx < 'hE0) || (idx == 'hE4) || (idx == 'hE5) ||
              (idx >= 'hE9 && idx <= 'hED) || (idx == 'hF3) ||
              (idx == 'hF5) || (idx == 'hF7) ||
              (idx >= 'hF9 && idx <= 'hFB) || (idx >= 'hFD);
    return !blocked;
  endfunction

  function automatic logic [7:0] regResetVal(input int idx);
    case (idx)
      'hE0:    return 8'h3C;
      'hE2:    return 8'h03;
      'hE3:    return 8'hFC;
      'hE6:    return 8'hDE;
      'hE7:    return 8'hFE;
      'hE8:    return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

  // Value lock: two registers only take one data value.
  function automatic logic valueAllowed(input logic [7:0] idx, input logic [7:0] d);
    if (idx == 8'hE7) return d == 8'hFE;
    if (idx == 8'hE8) return d == 8'hBE;
    return 1'b1;
  endfunction

endpackage

// File: rtl/cfgwin_ctrl.sv
module cfgwin_ctrl
  import cfgwin_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
  parameter logic [7:0] EN_OFFSET = 8'h85,
  parameter int EN_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCfgWr,
  input  logic [7:0]        hostCfgOffset,
  input  logic [7:0]        hostCfgData,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  output cfgStrobes_t       strb,
  output logic              winEn,
  output logic              claim
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

  logic hitIdx;
  logic hitData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winEn <= 1'b0;
    end else if (hostCfgWr && hostCfgOffset == EN_OFFSET) begin
      winEn <= hostCfgData[EN_BIT];
    end
  end

  always_comb begin
    hitIdx      = winEn && (ioAddr == BASE_ADDR);
    hitData     = winEn && (ioAddr == DATA_ADDR);
    strb.idxWr  = hitIdx && ioWr;
    strb.idxRd  = hitIdx && ioRd && !ioWr;
    strb.dataWr = hitData && ioWr;
    strb.dataRd = hitData && ioRd && !ioWr;
    claim       = (hitIdx || hitData) && (ioWr || ioRd);
  end
endmodule

// File: rtl/cfgwin_dp.sv
module cfgwin_dp
  import cfgwin_pkg::*;
#(
  parameter int NUM_REGS = 256,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobes_t       strb,
  input  logic [DATA_W-1:0] ioWdata,
  output logic [DATA_W-1:0] ioRdata,
  output logic [DATA_W-1:0] idxQ,
  output logic              wrAccept
);
  localparam logic [DATA_W-1:0] IDLE_DATA = '1;

  logic [DATA_W-1:0] regQ [NUM_REGS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
    end else if (strb.idxWr) begin
      idxQ <= ioWdata;
    end
  end

  assign wrAccept = strb.dataWr && regIsWritable(int'(idxQ)) && valueAllowed(idxQ, ioWdata);

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    localparam logic [DATA_W-1:0] RST_VAL = regResetVal(g);
    if (regIsWritable(g)) begin : gFlop
      always_ff @(posedge clk) begin
        if (!rstN) begin
          regQ[g] <= RST_VAL;
        end else if (wrAccept && idxQ == DATA_W'(g)) begin
          regQ[g] <= ioWdata;
        end
      end
    end else begin : gFixed
      assign regQ[g] = RST_VAL;
    end
  end

  always_comb begin
    if (strb.dataRd)     ioRdata = regQ[idxQ];
    else if (strb.idxRd) ioRdata = idxQ;
    else                 ioRdata = IDLE_DATA;
  end
endmodule

// File: rtl/cfgwin_top.sv
module cfgwin_top
  import cfgwin_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
  parameter logic [7:0] EN_OFFSET = 8'h85,
  parameter int EN_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCfgWr,
  input  logic [7:0]        hostCfgOffset,
  input  logic [7:0]        hostCfgData,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [7:0]        ioWdata,
  output logic [7:0]        ioRdata,
  output logic              ioAck
);
  cfgStrobes_t strb;
  logic        winEn;
  logic [7:0]  idxQ;
  logic        wrAccept;

  cfgwin_ctrl #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .EN_OFFSET(EN_OFFSET), .EN_BIT(EN_BIT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .hostCfgWr(hostCfgWr), .hostCfgOffset(hostCfgOffset),
    .hostCfgData(hostCfgData), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .strb(strb), .winEn(winEn), .claim(ioAck)
  );

  cfgwin_dp #(.NUM_REGS(256), .DATA_W(8)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .ioWdata(ioWdata),
    .ioRdata(ioRdata), .idxQ(idxQ), .wrAccept(wrAccept)
  );
endmodule

// File: rtl/cfgwin_chk.sv
module cfgwin_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostCfgWr,
  input logic [7:0]        hostCfgOffset,
  input logic [7:0]        hostCfgData,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioWr,
  input logic [7:0]        ioWdata,
  input logic [7:0]        ioRdata,
  input logic              ioAck,
  input logic              winEn,
  input logic [7:0]        idxQ,
  input logic              wrAccept
);
  // R2
  win_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostCfgWr && hostCfgOffset == 8'h85) |=> (winEn == $past(hostCfgData[1])));

  // R3
  index_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAck && ioAddr == BASE_ADDR) |=> (idxQ == $past(ioWdata)));

  // R6
  protect_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrAccept |-> (idxQ >= 8'hE0 && idxQ != 8'hE4 && idxQ != 8'hF3 && idxQ != 8'hFF));

  // R7
  value_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrAccept && (idxQ == 8'hE7 || idxQ == 8'hE8)) |->
      (ioWdata == (idxQ == 8'hE7 ? 8'hFE : 8'hBE)));

  // R8
  closed_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !winEn |-> (!ioAck && ioRdata == 8'hFF));

  // R9
  addr_claim_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioAck |-> (ioAddr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]));
endmodule

bind cfgwin_top cfgwin_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) uChk (
  .clk(clk), .rstN(rstN), .hostCfgWr(hostCfgWr), .hostCfgOffset(hostCfgOffset),
  .hostCfgData(hostCfgData), .ioAddr(ioAddr), .ioWr(ioWr), .ioWdata(ioWdata),
  .ioRdata(ioRdata), .ioAck(ioAck), .winEn(winEn), .idxQ(idxQ), .wrAccept(wrAccept)
);

// File: tb/cfgwin_top_test.sv
module cfgwin_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostCfgWr = 1'b0;
  logic [7:0]  hostCfgOffset = '0;
  logic [7:0]  hostCfgData = '0;
  logic [15:0] ioAddr = '0;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic [7:0]  ioWdata = '0;
  logic [7:0]  ioRdata;
  logic        ioAck;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfgwin_top uut (
    .clk(clk), .rstN(rstN), .hostCfgWr(hostCfgWr), .hostCfgOffset(hostCfgOffset),
    .hostCfgData(hostCfgData), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .ioAck(ioAck)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual {ack,data}=%h expected %h", req, act, exp);
    end
  endtask

  task automatic hostCfg(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    hostCfgWr = 1'b1; hostCfgOffset = off; hostCfgData = d;
    @(negedge clk);
    hostCfgWr = 1'b0;
  endtask

  task automatic ioWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWdata = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic ioRead(input logic [15:0] a, output logic [8:0] res);
    @(negedge clk);
    ioAddr = a; ioRd = 1'b1;
    #1 res = {ioAck, ioRdata};
    @(negedge clk);
    ioRd = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] idx, output logic [8:0] res);
    ioWrite(16'h03F0, idx);
    ioRead(16'h03F1, res);
  endtask

  task automatic testReset();
    logic [8:0] r;
    ioRead(16'h03F0, r); check("R1 idx port closed", r, 9'h0FF);
    ioRead(16'h03F1, r); check("R1 data port closed", r, 9'h0FF);
  endtask

  task automatic testEnable();
    logic [8:0] r;
    hostCfg(8'h84, 8'h02);
    ioRead(16'h03F0, r); check("R2 other offset ignored", r, 9'h0FF);
    hostCfg(8'h85, 8'hFD);
    ioRead(16'h03F0, r); check("R2 bit1 clear stays closed", r, 9'h0FF);
    hostCfg(8'h85, 8'h02);
    ioRead(16'h03F0, r); check("R3 index resets to 0", r, 9'h100);
  endtask

  task automatic testResetValues();
    logic [8:0] r;
    readReg(8'hE0, r); check("R4 E0", r, 9'h13C);
    readReg(8'hE1, r); check("R4 E1", r, 9'h100);
    readReg(8'hE2, r); check("R4 E2", r, 9'h103);
    readReg(8'hE3, r); check("R4 E3", r, 9'h1FC);
    readReg(8'hE6, r); check("R4 E6", r, 9'h1DE);
    readReg(8'hE7, r); check("R4 E7", r, 9'h1FE);
    readReg(8'hE8, r); check("R4 E8", r, 9'h1BE);
    readReg(8'h40, r); check("R4 40", r, 9'h100);
    ioRead(16'h03F0, r); check("R3 index readback", r, 9'h140);
  endtask

  task automatic testWritable();
    logic [8:0] r;
    ioWrite(16'h03F0, 8'hE0); ioWrite(16'h03F1, 8'hA5);
    readReg(8'hE0, r); check("R5 E0 write", r, 9'h1A5);
    ioWrite(16'h03F0, 8'hEE); ioWrite(16'h03F1, 8'h5A);
    readReg(8'hEE, r); check("R5 EE write", r, 9'h15A);
    ioWrite(16'h03F0, 8'hFC); ioWrite(16'h03F1, 8'h81);
    readReg(8'hFC, r); check("R5 FC write", r, 9'h181);
    ioWrite(16'h03F0, 8'hF8); ioWrite(16'h03F1, 8'h33);
    readReg(8'hF8, r); check("R5 F8 write", r, 9'h133);
  endtask

  task automatic testProtected();
    logic [8:0] r;
    logic [7:0] idxs [6] = '{8'h00, 8'hDF, 8'hE4, 8'hEA, 8'hF3, 8'hFF};
    for (int i = 0; i < 6; i++) begin
      ioWrite(16'h03F0, idxs[i]); ioWrite(16'h03F1, 8'h77);
      readReg(idxs[i], r); check("R6 protected index", r, 9'h100);
    end
  endtask

  task automatic testValueLock();
    logic [8:0] r;
    ioWrite(16'h03F0, 8'hE7); ioWrite(16'h03F1, 8'h00);
    readReg(8'hE7, r); check("R7 E7 rejects 00", r, 9'h1FE);
    ioWrite(16'h03F0, 8'hE8); ioWrite(16'h03F1, 8'hFF);
    readReg(8'hE8, r); check("R7 E8 rejects FF", r, 9'h1BE);
    ioWrite(16'h03F0, 8'hE8); ioWrite(16'h03F1, 8'hBE);
    readReg(8'hE8, r); check("R7 E8 takes BE", r, 9'h1BE);
  endtask

  task automatic testClosed();
    logic [8:0] r;
    ioWrite(16'h03F0, 8'hE0);
    hostCfg(8'h85, 8'h00);
    ioRead(16'h03F1, r); check("R8 closed read", r, 9'h0FF);
    ioWrite(16'h03F0, 8'hE1);
    ioWrite(16'h03F1, 8'h99);
    hostCfg(8'h85, 8'h02);
    ioRead(16'h03F0, r); check("R8 index kept", r, 9'h1E0);
    ioRead(16'h03F1, r); check("R8 E0 kept", r, 9'h1A5);
    readReg(8'hE1, r); check("R8 E1 kept", r, 9'h100);
  endtask

  task automatic testOtherAddr();
    logic [8:0] r;
    ioWrite(16'h03F0, 8'hE0);
    ioRead(16'h03F2, r); check("R9 3F2 unclaimed", r, 9'h0FF);
    ioRead(16'h02F0, r); check("R9 2F0 unclaimed", r, 9'h0FF);
    ioWrite(16'h02F0, 8'h12);
    ioWrite(16'h13F1, 8'h44);
    ioRead(16'h03F0, r); check("R9 index unchanged", r, 9'h1E0);
    ioRead(16'h03F1, r); check("R9 E0 unchanged", r, 9'h1A5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testEnable();
    testResetValues();
    testWritable();
    testProtected();
    testValueLock();
    testClosed();
    testOtherAddr();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule